// File: doc/BRIEF.md
# Flash Ready/Busy and Hardware Reset Controller

This block models the control side of a byte-wide NOR flash device. It watches the host's write strobes and command bytes and recognises the unlock sequences for program and erase. When a sequence completes, it flags the device as busy. While busy, it turns away new commands, with one exception: a running erase can be suspended and later resumed. A completion pulse from an abstract algorithm engine ends the operation and returns the device to read mode.

The busy indication is a pull-low enable. When it is high, the device pulls a shared, externally pulled-up ready line low. Several devices can therefore share one line as a wired-AND.

A hardware reset pin is synchronised into the clock domain and handled as follows:
- A low pulse shorter than the minimum width is ignored.
- A qualified pulse aborts any running operation a fixed time after the falling edge.
- While the pin is low, data outputs are tri-stated, writes are refused and busy is shown.
- After the pin rises, a wake-up delay must pass before outputs are enabled and writes are accepted again.

Top module: `nor_busy_ctrl`

## Requirements
- R1: The write sequence 0xAA, 0x55, 0xA0 followed by any fourth byte starts a program. Busy (`busy_pull`=1) is first seen after the fourth write strobe, never after the third. `op_mode` reads 0 for read mode, 1 for program, 2 for erase and 3 for erase suspended.
- R2: The write sequence 0xAA, 0x55, 0x80, 0xAA, 0x55, then 0x30 or 0x10 starts an erase (`op_mode`=2). Busy is first seen after the sixth write strobe and is still low after the fifth.
- R3: Any write whose byte does not match the expected sequence step returns the recogniser to its first step, so no operation starts.
- R4: While a program or erase is running, full program or erase sequences are ignored. The suspend byte 0xB0 is ignored during a program.
- R5: Writing 0xB0 during an erase enters the suspended state (`op_mode`=3) and releases busy.
- R6: In the suspended state, a completion pulse and command sequences are ignored. A single write of 0x30 resumes the erase and busy is shown again.
- R7: A completion pulse on `algo_done` during a program or erase releases busy and returns to read mode. After system reset the block is in read mode, not busy, with outputs enabled.
- R8: While the synchronised reset pin is low, `busy_pull` is 1 and `data_oe` is 0.
- R9: A reset pin low pulse shorter than `RST_MIN_CYC` cycles does not disturb the running operation.
- R10: A reset pulse of at least `RST_MIN_CYC` cycles aborts the running operation `ABORT_CYC` cycles after the fall, not earlier, even if the pin has already risen. Writes are refused while the pin stays low.
- R11: After the reset pin rises, `data_oe` stays 0 and writes are refused for `WAKE_CYC` cycles after the synchronised rise.
- R12: Two instances sharing one pulled-up ready line read it low when either one pulls and high only when neither does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_reset_n | input | 1 | Asynchronous active-low hardware reset pin |
| we_pulse | input | 1 | One-cycle write strobe, sampled on the rising clock edge |
| cmd_byte | input | 8 | Command/data byte carried with the write strobe |
| algo_done | input | 1 | Completion pulse from the algorithm engine |
| busy_pull | output | 1 | Pull-low enable for the shared open-drain ready line (1 = busy) |
| data_oe | output | 1 | Data output enable (0 = tri-stated) |
| op_mode | output | 2 | Operation state: 0 read, 1 program, 2 erase, 3 erase suspended |

## Verification
The main checks drive several sequence patterns and see that busy appears at exactly the right write:
- a clean program sequence, where busy rises on the fourth write and not the third;
- a clean erase sequence, with both erase codes, where busy rises on the sixth write and not the fifth;
- sequences broken at a middle step, which show that the recogniser restarts rather than resuming.

Further patterns separate the busy-time filter from the suspend exception:
- full sequences issued during a program and during an erase;
- 0xB0 issued during a program and during an erase;
- completion pulses issued during suspend.

Reset is tried with three pulse lengths:
- a short pulse, which must leave the operation intact;
- a qualified pulse released early, where the abort still arrives on schedule;
- a held pulse, after which standby refuses writes and wake-up delays output enable.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_SUSP  = 2'd3
  } op_e;

  localparam logic [7:0] UNLK_A      = 8'hAA;
  localparam logic [7:0] UNLK_B      = 8'h55;
  localparam logic [7:0] SETUP_PROG  = 8'hA0;
  localparam logic [7:0] SETUP_ERASE = 8'h80;
  localparam logic [7:0] ERASE_SECT  = 8'h30;
  localparam logic [7:0] ERASE_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  // counter width able to hold the value maxv
  function automatic int unsigned cnt_w(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // expected unlock byte at a given sequence step (steps 0,1 and 3,4)
  function automatic logic [7:0] unlock_byte(logic [2:0] step);
    return (step == 3'd0 || step == 3'd3) ? UNLK_A : UNLK_B;
  endfunction

  function automatic logic is_erase_code(logic [7:0] b);
    return (b == ERASE_SECT) || (b == ERASE_CHIP);
  endfunction

  function automatic logic is_busy_op(op_e m);
    return (m == OP_PROG) || (m == OP_ERASE);
  endfunction

endpackage

// File: rtl/nbc_rst_timer.sv
module nbc_rst_timer
  import nbc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_MIN_CYC = 50,
  parameter int unsigned ABORT_CYC   = 2000,
  parameter int unsigned WAKE_CYC    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_low,
  output logic abort_o,
  output logic access_ok
);

  localparam int unsigned TW = cnt_w(ABORT_CYC);
  localparam int unsigned WW = cnt_w(WAKE_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TW-1:0]          tmr;
  logic                   run, qual, parked, at_end, awake;

  // synchroniser chain for the asynchronous pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else begin
      sync_q[0] <= pin_n;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];
  assign at_end  = run && (tmr == TW'(ABORT_CYC - 1));
  assign abort_o = at_end && qual;

  // one timer: qualifies the pulse width, then times the abort from the fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; tmr <= '0; qual <= 1'b0; parked <= 1'b0;
    end else if (!run) begin
      if (!pin_low) parked <= 1'b0;
      else if (!parked) begin
        run  <= 1'b1;
        tmr  <= TW'(1);
        qual <= (RST_MIN_CYC <= 1);
      end
    end else if (!pin_low && !qual) begin
      run <= 1'b0; tmr <= '0;
    end else if (at_end) begin
      run <= 1'b0; tmr <= '0; qual <= 1'b0; parked <= pin_low;
    end else begin
      tmr <= tmr + 1'b1;
      if (pin_low && tmr >= TW'(RST_MIN_CYC - 1)) qual <= 1'b1;
    end
  end

  generate
    if (WAKE_CYC == 0) begin : g_nowake
      assign awake = 1'b1;
    end else begin : g_wake
      logic [WW-1:0] wk;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    wk <= WW'(WAKE_CYC);
        else if (pin_low)              wk <= '0;
        else if (wk != WW'(WAKE_CYC))  wk <= wk + 1'b1;
      end
      assign awake = (wk == WW'(WAKE_CYC));
    end
  endgenerate

  assign access_ok = !pin_low && awake;

endmodule

// File: rtl/nbc_cmd_seq.sv
module nbc_cmd_seq
  import nbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic       we,
  input  logic [7:0] din,
  output logic       start_prog,
  output logic       start_erase
);

  logic [2:0] step, nstep;
  logic       er, ner;

  always_comb begin
    start_prog  = 1'b0;
    start_erase = 1'b0;
    nstep       = step;
    ner         = er;
    if (!en || clr) begin
      nstep = 3'd0;
    end else if (we) begin
      nstep = 3'd0;
      case (step)
        3'd0, 3'd1, 3'd4: if (din == unlock_byte(step)) nstep = 3'(step + 3'd1);
        3'd2: begin
          if (din == SETUP_PROG)       begin nstep = 3'd3; ner = 1'b0; end
          else if (din == SETUP_ERASE) begin nstep = 3'd3; ner = 1'b1; end
        end
        3'd3: begin
          if (!er) start_prog = 1'b1;
          else if (din == unlock_byte(step)) nstep = 3'd4;
        end
        3'd5: if (is_erase_code(din)) start_erase = 1'b1;
        default: nstep = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin step <= 3'd0; er <= 1'b0; end
    else begin step <= nstep; er <= ner; end
  end

endmodule

// File: rtl/nbc_op_fsm.sv
module nbc_op_fsm
  import nbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_prog,
  input  logic       start_erase,
  input  logic       wr_ok,
  input  logic [7:0] din,
  input  logic       done,
  input  logic       abort,
  output op_e        mode
);

  op_e nmode;

  always_comb begin
    nmode = mode;
    unique case (mode)
      OP_READ: begin
        if (start_prog)       nmode = OP_PROG;
        else if (start_erase) nmode = OP_ERASE;
      end
      OP_PROG:  if (done) nmode = OP_READ;
      OP_ERASE: begin
        if (done)                                nmode = OP_READ;
        else if (wr_ok && din == CMD_SUSPEND)    nmode = OP_SUSP;
      end
      OP_SUSP:  if (wr_ok && din == CMD_RESUME) nmode = OP_ERASE;
      default:  nmode = OP_READ;
    endcase
    if (abort) nmode = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= OP_READ;
    else        mode <= nmode;
  end

endmodule

// File: rtl/nor_busy_ctrl.sv
module nor_busy_ctrl
  import nbc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_MIN_CYC = 50,
  parameter int unsigned ABORT_CYC   = 2000,
  parameter int unsigned WAKE_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_reset_n,
  input  logic       we_pulse,
  input  logic [7:0] cmd_byte,
  input  logic       algo_done,
  output logic       busy_pull,
  output logic       data_oe,
  output logic [1:0] op_mode
);

  // named internal events, also observed by the bound checker
  logic pin_low, access_ok, abort_evt;
  logic start_prog, start_erase, wr_ok;
  op_e  mode;

  nbc_rst_timer #(
    .SYNC_STAGES(SYNC_STAGES), .RST_MIN_CYC(RST_MIN_CYC),
    .ABORT_CYC(ABORT_CYC),     .WAKE_CYC(WAKE_CYC)
  ) u_rst (
    .clk(clk), .rst_n(rst_n), .pin_n(hw_reset_n),
    .pin_low(pin_low), .abort_o(abort_evt), .access_ok(access_ok)
  );

  assign wr_ok = we_pulse && access_ok;

  nbc_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(access_ok && mode == OP_READ), .clr(abort_evt),
    .we(we_pulse), .din(cmd_byte),
    .start_prog(start_prog), .start_erase(start_erase)
  );

  nbc_op_fsm u_op (
    .clk(clk), .rst_n(rst_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .wr_ok(wr_ok), .din(cmd_byte), .done(algo_done),
    .abort(abort_evt), .mode(mode)
  );

  assign busy_pull = pin_low || is_busy_op(mode);
  assign data_oe   = access_ok;
  assign op_mode   = mode;

endmodule

// File: rtl/nor_busy_ctrl_chk.sv
module nor_busy_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_low,
  input logic       access_ok,
  input logic       abort_evt,
  input logic       start_prog,
  input logic       start_erase,
  input logic       wr_ok,
  input logic [7:0] cmd_byte,
  input logic       algo_done,
  input logic       busy_pull,
  input logic       data_oe,
  input logic [1:0] op_mode
);

  // R1
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog && !abort_evt |=> op_mode == 2'd1);

  // R2
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase && !abort_evt |=> op_mode == 2'd2);

  // R4
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode != 2'd0 |-> !start_prog && !start_erase);

  // R4
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode == 2'd1 && !algo_done && !abort_evt |=> op_mode == 2'd1);

  // R5
  susp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode == 2'd3 && !pin_low |-> !busy_pull);

  // R6
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode == 2'd3 && !(wr_ok && cmd_byte == 8'h30) && !abort_evt |=> op_mode == 2'd3);

  // R8
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_low |-> busy_pull && !data_oe);

  // R10
  abort_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> op_mode == 2'd0);

  // R11
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ok |-> !start_prog && !start_erase);

endmodule

bind nor_busy_ctrl nor_busy_ctrl_chk u_chk (.*);

// File: tb/nor_busy_ctrl_tb.sv
module nor_busy_ctrl_tb;

  localparam int unsigned MINC  = 50;
  localparam int unsigned ABRT  = 2000;
  localparam int unsigned WAKE  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       we = 1'b0, we2 = 1'b0;
  logic [7:0] cmd = 8'h00, cmd2 = 8'h00;
  logic       done = 1'b0, done2 = 1'b0;
  logic       busy, busy2, oe, oe2;
  logic [1:0] mode, mode2;
  logic       ry_line;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nor_busy_ctrl #(.RST_MIN_CYC(MINC), .ABORT_CYC(ABRT), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(pin_n), .we_pulse(we), .cmd_byte(cmd),
    .algo_done(done), .busy_pull(busy), .data_oe(oe), .op_mode(mode));

  nor_busy_ctrl #(.RST_MIN_CYC(MINC), .ABORT_CYC(ABRT), .WAKE_CYC(WAKE)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(1'b1), .we_pulse(we2), .cmd_byte(cmd2),
    .algo_done(done2), .busy_pull(busy2), .data_oe(oe2), .op_mode(mode2));

  // shared pulled-up line, wired-AND of the two open-drain outputs
  assign ry_line = ~(busy | busy2);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    we = 1'b1; cmd = b;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr2(logic [7:0] b);
    we2 = 1'b1; cmd2 = b;
    @(negedge clk);
    we2 = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_prog();
    wr(8'hAA); wr(8'h55); wr(8'hA0); wr(8'h3C);
  endtask

  task automatic start_erase(logic [7:0] code);
    wr(8'hAA); wr(8'h55); wr(8'h80); wr(8'hAA); wr(8'h55); wr(code);
  endtask

  task automatic t_reset_state();
    chk("R7", "reset busy", int'(busy), 0);
    chk("R7", "reset oe", int'(oe), 1);
    chk("R7", "reset mode", int'(mode), 0);
  endtask

  task automatic t_program();
    wr(8'hAA); wr(8'h55); wr(8'hA0);
    chk("R1", "busy after 3rd write", int'(busy), 0);
    wr(8'h12);
    chk("R1", "busy after 4th write", int'(busy), 1);
    chk("R1", "mode program", int'(mode), 1);
    wait_cyc(5);
    pulse_done();
    chk("R7", "busy after done", int'(busy), 0);
    chk("R7", "mode after done", int'(mode), 0);
  endtask

  task automatic t_erase();
    wr(8'hAA); wr(8'h55); wr(8'h80); wr(8'hAA); wr(8'h55);
    chk("R2", "busy after 5th write", int'(busy), 0);
    wr(8'h30);
    chk("R2", "busy after 6th write", int'(busy), 1);
    chk("R2", "mode erase", int'(mode), 2);
    pulse_done();
    start_erase(8'h10);
    chk("R2", "chip erase code mode", int'(mode), 2);
    pulse_done();
    chk("R7", "erase done mode", int'(mode), 0);
  endtask

  task automatic t_mismatch();
    wr(8'hAA); wr(8'h12); wr(8'h55); wr(8'hA0); wr(8'h77);
    chk("R3", "broken unlock mode", int'(mode), 0);
    wr(8'hAA); wr(8'h55); wr(8'h80); wr(8'hAA); wr(8'h99); wr(8'h30);
    chk("R3", "broken erase mode", int'(mode), 0);
    chk("R3", "broken erase busy", int'(busy), 0);
    wr(8'hAA); wr(8'h55); wr(8'h44); wr(8'h3C);
    chk("R3", "bad setup mode", int'(mode), 0);
  endtask

  task automatic t_busy_filter();
    start_prog();
    start_erase(8'h30);
    chk("R4", "erase seq during program", int'(mode), 1);
    wr(8'hB0);
    chk("R4", "suspend during program", int'(mode), 1);
    chk("R4", "busy kept", int'(busy), 1);
    pulse_done();
    start_erase(8'h30);
    start_prog();
    chk("R4", "program seq during erase", int'(mode), 2);
    pulse_done();
  endtask

  task automatic t_suspend();
    start_erase(8'h30);
    wr(8'hB0);
    chk("R5", "mode suspended", int'(mode), 3);
    chk("R5", "busy released", int'(busy), 0);
    pulse_done();
    chk("R6", "done ignored in suspend", int'(mode), 3);
    start_prog();
    chk("R6", "program seq ignored in suspend", int'(mode), 3);
    wr(8'h30);
    chk("R6", "resume mode", int'(mode), 2);
    chk("R6", "resume busy", int'(busy), 1);
    pulse_done();
    chk("R7", "mode after resumed erase", int'(mode), 0);
  endtask

  task automatic t_rst_hold();
    start_erase(8'h30);
    pin_n = 1'b0;
    wait_cyc(4);
    chk("R8", "busy while pin low", int'(busy), 1);
    chk("R8", "oe while pin low", int'(oe), 0);
    wait_cyc(996);
    chk("R10", "no early abort", int'(mode), 2);
    wait_cyc(1010);
    chk("R10", "aborted to read", int'(mode), 0);
    chk("R8", "busy in standby", int'(busy), 1);
    start_prog();
    chk("R10", "writes refused in standby", int'(mode), 0);
    pin_n = 1'b1;
    wait_cyc(WAKE + 6);
    chk("R11", "oe after wake", int'(oe), 1);
    chk("R8", "busy after release", int'(busy), 0);
  endtask

  task automatic t_short_pulse();
    start_prog();
    pin_n = 1'b0;
    wait_cyc(MINC / 2 - 4);
    chk("R8", "busy during short pulse", int'(busy), 1);
    wait_cyc(4);
    pin_n = 1'b1;
    wait_cyc(ABRT + 100);
    chk("R9", "short pulse no abort", int'(mode), 1);
    pulse_done();
  endtask

  task automatic t_qual_release();
    start_prog();
    pin_n = 1'b0;
    wait_cyc(2 * MINC);
    pin_n = 1'b1;
    wait_cyc(1000 - 2 * MINC);
    chk("R10", "released pulse not yet aborted", int'(mode), 1);
    wait_cyc(1010);
    chk("R10", "released pulse aborts on time", int'(mode), 0);
    chk("R10", "busy after abort", int'(busy), 0);
  endtask

  task automatic t_wake();
    pin_n = 1'b0;
    wait_cyc(2 * MINC);
    pin_n = 1'b1;
    start_prog();
    chk("R11", "writes refused in wake", int'(mode), 0);
    wait_cyc(WAKE - 4);
    chk("R11", "oe still off in wake", int'(oe), 0);
    wait_cyc(5);
    chk("R11", "oe on after wake", int'(oe), 1);
    wait_cyc(ABRT + 50);
  endtask

  task automatic t_wired();
    chk("R12", "line idle", int'(ry_line), 1);
    wr2(8'hAA); wr2(8'h55); wr2(8'hA0); wr2(8'h01);
    chk("R12", "line low from second", int'(ry_line), 0);
    start_prog();
    done2 = 1'b1; @(negedge clk); done2 = 1'b0;
    chk("R12", "line low from first only", int'(ry_line), 0);
    pulse_done();
    chk("R12", "line high when none pull", int'(ry_line), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset_state();
    t_program();
    t_erase();
    t_mismatch();
    t_busy_filter();
    t_suspend();
    t_rst_hold();
    t_short_pulse();
    t_qual_release();
    t_wake();
    t_wired();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule